// File: doc/BRIEF.md
# Keyboard Controller Host Interface

This block is the host-facing register interface of a keyboard and mouse microcontroller. The host writes bytes into an input buffer and reads bytes from an output buffer that the embedded CPU fills. A status byte tells both sides which buffer is full. It also tells the CPU whether the last host byte is a command or data, which depends on the host address bit used for the write.

Host accesses go through a small state machine. It accepts each write or read strobe once, however many cycles the strobe is held. The machine has three states. `HB_IDLE` waits for an access. `HB_WRITE` waits for a write strobe to drop. `HB_READ` waits for a read strobe to drop. The named transitions are:

- `accept_write`: `HB_IDLE` to `HB_WRITE`, on select with write. A write wins if read is also high.
- `accept_read`: `HB_IDLE` to `HB_READ`, on select with read and no write. The address bit is latched on this transition.
- `write_release`: `HB_WRITE` to `HB_IDLE`, when select or write drops.
- `read_release`: `HB_READ` to `HB_IDLE`, when select or read drops. If the latched address bit was 0, this drains the output buffer.

Two interrupt lines, one for the keyboard and one for the mouse, come from two CPU-driven port bits. In direct mode each line simply follows its port bit. Once the CPU pulses the flags-enable strobe, the block switches to gated mode until reset. In gated mode the keyboard line is its port bit ANDed with output-buffer-full, and the mouse line is its port bit ANDed with input-buffer-empty.

Top module: `kbc_host_if`

## Requirements
- R1: While reset is active, and after it, the status byte, both interrupt lines and the flags mode are all 0.
- R2: A host write (select and write high) loads `host_wdata` into the input buffer and sets IBF, which is status bit 1, on the next clock. A strobe held for several cycles is taken only once, so data that changes while the strobe is held is not captured.
- R3: On each accepted host write, status bit 3 takes the value of `host_a2`: 1 marks a command and 0 marks data.
- R4: A CPU input-buffer read strobe clears IBF on the next clock. If a host write is accepted in the same cycle, IBF stays 1.
- R5: A CPU output-buffer write loads `cpu_obuf_wdata` and sets OBF, which is status bit 0, on the next clock.
- R6: While select and read are high, `host_rdata` shows the status byte when `host_a2`=1 and the output buffer when `host_a2`=0. Otherwise it is 0. Status bits 2 and 4 to 7 always read 0.
- R7: A host read with `host_a2`=0 clears OBF on the clock after the strobe drops. A status read does not clear OBF. A CPU output write in that same cycle keeps OBF at 1.
- R8: In direct mode, `kb_irq` equals port bit 0 (keyboard) and `ms_irq` equals port bit 1 (mouse). Both port bits are written together by `cpu_port_we`.
- R9: In gated mode, `kb_irq` is 1 only when port bit 0 is 1 and OBF is 1.
- R10: In gated mode, `ms_irq` is 1 only when port bit 1 is 1 and IBF is 0.
- R11: A one-cycle `cpu_flags_en` pulse switches the block to gated mode on the next clock. The block stays in gated mode until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host chip select, active high |
| host_a2 | input | 1 | Host address bit: 1 selects status or command, 0 selects data |
| host_wr | input | 1 | Host write strobe, active high |
| host_rd | input | 1 | Host read strobe, active high |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| cpu_ibuf_rd | input | 1 | CPU input-buffer read strobe |
| cpu_ibuf_data | output | 8 | Input buffer contents |
| cpu_obuf_wr | input | 1 | CPU output-buffer write strobe |
| cpu_obuf_wdata | input | 8 | CPU output-buffer data |
| cpu_port_we | input | 1 | CPU port-bit write strobe |
| cpu_port_wdata | input | 2 | Port bits: bit 0 keyboard, bit 1 mouse |
| cpu_flags_en | input | 1 | One-cycle strobe that enters gated mode |
| cpu_status | output | 8 | Status byte as seen by the CPU |
| kb_irq | output | 1 | Keyboard interrupt |
| ms_irq | output | 1 | Mouse interrupt |

## Verification
Directed patterns come first:
- A write strobe held over several cycles while its data changes, which tells single acceptance apart from re-capture on every cycle.
- A host write that collides with a CPU read, which shows which side wins on IBF.
- A status read next to a data read, which shows that only the data read drains OBF.
- Port bits set before and after the flags pulse, which separates direct mode from gated mode.

Random traffic then runs in each mode. Strobes overlap and are held for random lengths, and a cycle-level model is compared every clock. This exposes errors in hold-release tracking, in set-versus-clear priority and in the interrupt gating.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
    localparam int DATA_W   = 8;
    localparam int OBF_POS  = 0;
    localparam int IBF_POS  = 1;
    localparam int CMD_POS  = 3;
    localparam int IRQ_N    = 2;

    typedef enum logic [1:0] {
        HB_IDLE  = 2'd0,
        HB_WRITE = 2'd1,
        HB_READ  = 2'd2
    } hb_state_e;
endpackage

// File: rtl/kbc_host_fsm.sv
module kbc_host_fsm
    import kbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_sel,
    input  logic host_wr,
    input  logic host_rd,
    input  logic host_a2,
    output logic wr_accept,
    output logic obuf_drained
);
    hb_state_e state_q, state_d;
    logic      rd_a2_q;
    logic      wr_req, rd_req;

    assign wr_req = host_sel && host_wr;
    assign rd_req = host_sel && host_rd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HB_IDLE;
            rd_a2_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == HB_IDLE && !wr_req && rd_req)
                rd_a2_q <= host_a2;
        end
    end

    // next state and outputs
    always_comb begin
        state_d      = state_q;
        wr_accept    = 1'b0;
        obuf_drained = 1'b0;
        unique case (state_q)
            HB_IDLE: begin
                if (wr_req) begin
                    state_d   = HB_WRITE;
                    wr_accept = 1'b1;
                end else if (rd_req) begin
                    state_d = HB_READ;
                end
            end
            HB_WRITE: begin
                if (!wr_req) state_d = HB_IDLE;
            end
            HB_READ: begin
                if (!rd_req) begin
                    state_d      = HB_IDLE;
                    obuf_drained = !rd_a2_q;
                end
            end
            default: state_d = HB_IDLE;
        endcase
    end

    // R2
    single_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |=> !wr_accept);
endmodule

// File: rtl/kbc_buffers.sv
module kbc_buffers
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_accept,
    input  logic              host_a2,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              obuf_drained,
    input  logic              cpu_ibuf_rd,
    input  logic              cpu_obuf_wr,
    input  logic [DATA_W-1:0] cpu_obuf_wdata,
    output logic [DATA_W-1:0] ibuf_q,
    output logic [DATA_W-1:0] obuf_q,
    output logic              ibf_q,
    output logic              obf_q,
    output logic              cmd_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ibuf_q <= '0;
            ibf_q  <= 1'b0;
            cmd_q  <= 1'b0;
        end else if (wr_accept) begin
            ibuf_q <= host_wdata;
            ibf_q  <= 1'b1;
            cmd_q  <= host_a2;
        end else if (cpu_ibuf_rd) begin
            ibf_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            obuf_q <= '0;
            obf_q  <= 1'b0;
        end else if (cpu_obuf_wr) begin
            obuf_q <= cpu_obuf_wdata;
            obf_q  <= 1'b1;
        end else if (obuf_drained) begin
            obf_q <= 1'b0;
        end
    end

    // R2
    ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |=> ibf_q);
    // R3
    cmd_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |=> (cmd_q == $past(host_a2)));
    // R4
    ibf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ibuf_rd && !wr_accept) |=> !ibf_q);
    // R5
    obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_obuf_wr |=> obf_q);
    // R7
    obf_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (obuf_drained && !cpu_obuf_wr) |=> !obf_q);
endmodule

// File: rtl/kbc_irq_ctrl.sv
module kbc_irq_ctrl
    import kbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_port_we,
    input  logic [IRQ_N-1:0] cpu_port_wdata,
    input  logic             cpu_flags_en,
    input  logic             ibf,
    input  logic             obf,
    output logic [IRQ_N-1:0] irq
);
    logic [IRQ_N-1:0] port_q;
    logic [IRQ_N-1:0] gate_src;
    logic             gated_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q  <= '0;
            gated_q <= 1'b0;
        end else begin
            if (cpu_port_we)  port_q  <= cpu_port_wdata;
            if (cpu_flags_en) gated_q <= 1'b1;
        end
    end

    // channel 0 keyboard: output buffer full; channel 1 mouse: input buffer empty
    assign gate_src = {!ibf, obf};

    for (genvar i = 0; i < IRQ_N; i++) begin : g_irq
        assign irq[i] = gated_q ? (port_q[i] && gate_src[i]) : port_q[i];
    end

    // R11
    mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gated_q |=> gated_q);
    // R9
    kb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gated_q && !obf) |-> !irq[0]);
    // R10
    ms_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gated_q && ibf) |-> !irq[1]);
    // R8
    direct_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gated_q && cpu_port_we && !cpu_flags_en) |=> (irq == $past(cpu_port_wdata)));
endmodule

// File: rtl/kbc_host_if.sv
module kbc_host_if
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_a2,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              cpu_ibuf_rd,
    output logic [DATA_W-1:0] cpu_ibuf_data,
    input  logic              cpu_obuf_wr,
    input  logic [DATA_W-1:0] cpu_obuf_wdata,
    input  logic              cpu_port_we,
    input  logic [IRQ_N-1:0]  cpu_port_wdata,
    input  logic              cpu_flags_en,
    output logic [DATA_W-1:0] cpu_status,
    output logic              kb_irq,
    output logic              ms_irq
);
    logic              wr_accept, obuf_drained;
    logic              ibf, obf, cmd;
    logic [DATA_W-1:0] obuf;
    logic [IRQ_N-1:0]  irq;

    kbc_host_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_sel     (host_sel),
        .host_wr      (host_wr),
        .host_rd      (host_rd),
        .host_a2      (host_a2),
        .wr_accept    (wr_accept),
        .obuf_drained (obuf_drained)
    );

    kbc_buffers u_buf (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_accept      (wr_accept),
        .host_a2        (host_a2),
        .host_wdata     (host_wdata),
        .obuf_drained   (obuf_drained),
        .cpu_ibuf_rd    (cpu_ibuf_rd),
        .cpu_obuf_wr    (cpu_obuf_wr),
        .cpu_obuf_wdata (cpu_obuf_wdata),
        .ibuf_q         (cpu_ibuf_data),
        .obuf_q         (obuf),
        .ibf_q          (ibf),
        .obf_q          (obf),
        .cmd_q          (cmd)
    );

    kbc_irq_ctrl u_irq (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_port_we    (cpu_port_we),
        .cpu_port_wdata (cpu_port_wdata),
        .cpu_flags_en   (cpu_flags_en),
        .ibf            (ibf),
        .obf            (obf),
        .irq            (irq)
    );

    assign kb_irq = irq[0];
    assign ms_irq = irq[1];

    always_comb begin
        cpu_status          = '0;
        cpu_status[OBF_POS] = obf;
        cpu_status[IBF_POS] = ibf;
        cpu_status[CMD_POS] = cmd;
    end

    always_comb begin
        if (host_sel && host_rd) host_rdata = host_a2 ? cpu_status : obuf;
        else                     host_rdata = '0;
    end

    // R6
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_sel && host_rd) |-> (host_rdata == '0));
endmodule

// File: tb/kbc_host_if_tb.sv
module kbc_host_if_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 0, host_a2 = 0, host_wr = 0, host_rd = 0;
    logic [7:0] host_wdata = 0, host_rdata;
    logic       cpu_ibuf_rd = 0, cpu_obuf_wr = 0, cpu_port_we = 0, cpu_flags_en = 0;
    logic [7:0] cpu_ibuf_data, cpu_obuf_wdata = 0, cpu_status;
    logic [1:0] cpu_port_wdata = 0;
    logic       kb_irq, ms_irq;

    always #4 clk = ~clk;

    kbc_host_if u_dut (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int m_ibf, m_obf, m_cmd, m_ibuf, m_obuf, m_kb, m_ms, m_gated, m_phase, m_ra2;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_status();
        return m_obf + 2 * m_ibf + 8 * m_cmd;
    endfunction

    // phase: 0 waiting, 1 write held, 2 read held
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ibf = 0; m_obf = 0; m_cmd = 0; m_ibuf = 0; m_obuf = 0;
            m_kb = 0; m_ms = 0; m_gated = 0; m_phase = 0; m_ra2 = 0;
        end else begin
            int acc_w, acc_r, rel_r, rel_w;
            acc_w = (m_phase == 0) && host_sel && host_wr;
            acc_r = (m_phase == 0) && host_sel && host_rd && !host_wr;
            rel_r = (m_phase == 2) && !(host_sel && host_rd);
            rel_w = (m_phase == 1) && !(host_sel && host_wr);
            if (acc_w) begin
                m_ibuf = host_wdata; m_ibf = 1; m_cmd = host_a2;
            end else if (cpu_ibuf_rd) m_ibf = 0;
            if (cpu_obuf_wr) begin
                m_obuf = cpu_obuf_wdata; m_obf = 1;
            end else if (rel_r && m_ra2 == 0) m_obf = 0;
            if (cpu_port_we) begin
                m_kb = cpu_port_wdata[0]; m_ms = cpu_port_wdata[1];
            end
            if (cpu_flags_en) m_gated = 1;
            if (acc_w) m_phase = 1;
            else if (acc_r) begin m_phase = 2; m_ra2 = host_a2; end
            else if (rel_r || rel_w) m_phase = 0;
        end
    end

    // per-cycle comparison, 2 ns after the edge
    always @(posedge clk) begin
        if (rst_n && !done) begin
            int xr, xk, xm;
            #2;
            xr = (host_sel && host_rd) ? (host_a2 ? exp_status() : m_obuf) : 0;
            xk = m_gated ? (m_kb & m_obf) : m_kb;
            xm = m_gated ? (m_ms & (1 - m_ibf)) : m_ms;
            chk("R2 R4 ibf", cpu_status[1], m_ibf);
            chk("R2 ibuf data", cpu_ibuf_data, m_ibuf);
            chk("R3 cmd flag", cpu_status[3], m_cmd);
            chk("R5 R7 obf", cpu_status[0], m_obf);
            chk("R6 reserved status bits", {cpu_status[7:4], cpu_status[2]}, 0);
            chk("R6 host_rdata", host_rdata, xr);
            chk("R8 R9 R11 kb_irq", kb_irq, xk);
            chk("R8 R10 R11 ms_irq", ms_irq, xm);
        end
    end

    task automatic idle_all();
        host_sel = 0; host_wr = 0; host_rd = 0; cpu_ibuf_rd = 0;
        cpu_obuf_wr = 0; cpu_port_we = 0; cpu_flags_en = 0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        cyc(3);
        chk("R1 status in reset", cpu_status, 0);
        chk("R1 kb_irq in reset", kb_irq, 0);
        chk("R1 ms_irq in reset", ms_irq, 0);
        rst_n = 1;
        cyc(1);
        chk("R1 status after reset", cpu_status, 0);
        chk("R1 kb_irq after reset", kb_irq, 0);

        // R2/R3: held command write, data changes mid-strobe
        host_sel = 1; host_wr = 1; host_a2 = 1; host_wdata = 8'hA5;
        cyc(1);
        host_wdata = 8'h11;
        cyc(2);
        chk("R2 held write captured once", cpu_ibuf_data, 8'hA5);
        chk("R3 command flag set", cpu_status[3], 1);
        idle_all(); cyc(1);

        // R4: CPU read alone, then collision with host data write
        cpu_ibuf_rd = 1; cyc(1); cpu_ibuf_rd = 0;
        chk("R4 cpu read clears ibf", cpu_status[1], 0);
        host_sel = 1; host_wr = 1; host_a2 = 0; host_wdata = 8'h5A; cpu_ibuf_rd = 1;
        cyc(1);
        idle_all(); cyc(1);
        chk("R4 host write wins over cpu read", cpu_status[1], 1);
        chk("R3 data flag", cpu_status[3], 0);

        // R5/R6/R7: obuf fill, status read keeps it, data read drains it
        cpu_obuf_wr = 1; cpu_obuf_wdata = 8'h3C; cyc(1); cpu_obuf_wr = 0;
        host_sel = 1; host_rd = 1; host_a2 = 1; cyc(2);
        idle_all(); cyc(2);
        chk("R7 status read keeps obf", cpu_status[0], 1);
        host_sel = 1; host_rd = 1; host_a2 = 0; cyc(1);
        chk("R6 data read value", host_rdata, 8'h3C);
        cyc(1);
        idle_all(); cyc(1);
        chk("R7 data read drains obf", cpu_status[0], 0);

        // R8: direct mode follows port bits
        cpu_port_we = 1; cpu_port_wdata = 2'b11; cyc(1); idle_all();
        chk("R8 kb_irq direct", kb_irq, 1);
        chk("R8 ms_irq direct", ms_irq, 1);

        // R11: enter gated mode; obf=0 and ibf=1 now mask both lines
        cpu_flags_en = 1; cyc(1); idle_all();
        chk("R11 kb_irq gated", kb_irq, 0);
        chk("R11 ms_irq gated", ms_irq, 0);
        cpu_ibuf_rd = 1; cyc(1); idle_all();
        chk("R10 ms_irq after cpu read", ms_irq, 1);
        cpu_obuf_wr = 1; cpu_obuf_wdata = 8'h77; cyc(1); idle_all();
        chk("R9 kb_irq after obuf write", kb_irq, 1);

        // random traffic in gated mode, then reset and direct mode
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 1200; i++) begin
                host_sel       = ($urandom % 4) != 0;
                host_wr        = ($urandom % 5) == 0;
                host_rd        = ($urandom % 4) == 0;
                host_a2        = $urandom % 2;
                host_wdata     = $urandom;
                cpu_ibuf_rd    = ($urandom % 6) == 0;
                cpu_obuf_wr    = ($urandom % 6) == 0;
                cpu_obuf_wdata = $urandom;
                cpu_port_we    = ($urandom % 10) == 0;
                cpu_port_wdata = $urandom;
                cpu_flags_en   = 0;
                cyc(1);
            end
            idle_all();
            rst_n = 0; cyc(2); rst_n = 1; cyc(1);
        end
        cyc(2);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule